// File: doc/BRIEF.md
# Paged Virtual Address Translator

This block turns a 17-bit virtual word address into a 22-bit real word address. The upper eight address bits are a page number. They pick one of 256 page-frame entries, each 13 bits wide. That frame number is placed above the nine offset bits, which pass through unchanged. Alongside each frame entry sits a 2-bit permission code. The code is checked against the kind of access requested in the same cycle as the lookup. A disallowed access raises a fault in place of a valid address.

The sixteen lowest virtual addresses name the general registers. They always bypass the table and come out flagged as register references. With mapping switched off, every address passes straight through, zero-extended, and no permission check is made. Software-side logic loads frame entries and permission codes through a single write port. Each translation request returns its result exactly one clock later.

Top module: `vat_translator`

## Requirements
- R1: A synchronous active-high reset clears every frame entry to 0, every permission code to 00, and drives out_valid, out_fault, out_regref low with out_addr zero.
- R2: A request whose virtual address is below 16 returns out_regref=1, out_valid=1, out_fault=0 and out_addr equal to the address zero-extended. This holds whatever the mapping mode and the permission codes.
- R3: In mapping mode, for an address of 16 or more, virtual bits 16..8 minus the lowest (bits 16..9) form the page index, and an allowed access returns out_addr bits 21..9 equal to that page's frame entry.
- R4: An allowed mapped access returns out_addr bits 8..0 equal to virtual address bits 8..0.
- R5: With map_on low, an address of 16 or more returns out_valid=1, out_regref=0, out_fault=0 and out_addr equal to the virtual address zero-extended, with no permission check.
- R6: Permission codes: 00 allows all access kinds, 01 allows read and fetch, 10 allows read only, 11 allows nothing. A denied mapped access returns out_fault=1, out_valid=0, out_addr zero.
- R7: req_kind encodes 00 read, 01 write, 10 instruction fetch; 11 is checked as a read.
- R8: A write with wr_sel=0 loads wr_data into the frame entry at wr_page; with wr_sel=1 it loads wr_data bits 1..0 into that page's permission code. The new value takes effect at the next clock edge, so a translation in the same cycle uses the old value.
- R9: Results appear on the clock edge after the request; a cycle with req_valid low produces out_valid, out_fault and out_regref low and out_addr zero one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_sel | input | 1 | 0 = frame entry, 1 = permission code |
| wr_page | input | 8 | Page index to write |
| wr_data | input | 13 | Frame number, or permission code in bits 1..0 |
| req_valid | input | 1 | Translation request |
| req_addr | input | 17 | Virtual word address |
| req_kind | input | 2 | Access kind (00 read, 01 write, 10 fetch) |
| map_on | input | 1 | Mapping mode enable |
| out_valid | output | 1 | Real address valid |
| out_addr | output | 22 | Real word address |
| out_regref | output | 1 | Address names a general register |
| out_fault | output | 1 | Access denied by the page's permission code |

## Verification
A corrupted frame entry appears only when a page that uses it is next translated in mapping mode. It then shows as wrong upper address bits one cycle after that request. A corrupted permission code appears as a spurious or missing fault on the next access of a kind the code distinguishes. The bench therefore writes tables with varied data and sweeps every page and every access kind against them, comparing each cycle with a behavioural model. A stage that misses the register window or the pass-through mode misroutes the address on the very next cycle.

// File: rtl/vat_pkg.sv
package vat_pkg;
    localparam int VA_W     = 17;
    localparam int PAGE_W   = 8;
    localparam int OFF_W    = VA_W - PAGE_W;
    localparam int FRAME_W  = 13;
    localparam int RA_W     = FRAME_W + OFF_W;
    localparam int PERM_W   = 2;
    localparam int REG_SPAN = 16;

    typedef enum logic [1:0] {
        K_READ  = 2'd0,
        K_WRITE = 2'd1,
        K_FETCH = 2'd2,
        K_SPARE = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        P_RWX  = 2'd0,
        P_RX   = 2'd1,
        P_RO   = 2'd2,
        P_NONE = 2'd3
    } perm_e;

    typedef struct packed {
        logic            valid;
        logic            regref;
        logic            fault;
        logic [RA_W-1:0] addr;
    } xlat_s;

    function automatic logic perm_allows(perm_e p, kind_e k);
        logic ok;
        case (p)
            P_RWX:   ok = 1'b1;
            P_RX:    ok = (k != K_WRITE);
            P_RO:    ok = (k == K_READ) || (k == K_SPARE);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction
endpackage

// File: rtl/vat_page_table.sv
module vat_page_table #(
    parameter int IDX_W  = 8,
    parameter int DATA_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[widx] <= wdata;
        end
    end

    assign rdata = mem[ridx];
endmodule

// File: rtl/vat_perm_check.sv
module vat_perm_check
    import vat_pkg::*;
(
    input  perm_e code,
    input  kind_e kind,
    input  logic  checked,
    output logic  deny
);
    always_comb begin
        deny = checked && !perm_allows(code, kind);
    end
endmodule

// File: rtl/vat_out_stage.sv
module vat_out_stage
    import vat_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  xlat_s nxt,
    output xlat_s cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    // a denied access never carries a usable address (R6)
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (rst)
        cur.fault |-> (!cur.valid && cur.addr == '0));
    // register references are always granted (R2)
    p_regref_ok_r2: assert property (@(posedge clk) disable iff (rst)
        cur.regref |-> (cur.valid && !cur.fault));
endmodule

// File: rtl/vat_translator.sv
module vat_translator
    import vat_pkg::*;
#(
    parameter int P_VA_W    = VA_W,
    parameter int P_PAGE_W  = PAGE_W,
    parameter int P_FRAME_W = FRAME_W,
    parameter int P_RA_W    = RA_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [P_PAGE_W-1:0]  wr_page,
    input  logic [P_FRAME_W-1:0] wr_data,
    input  logic                 req_valid,
    input  logic [P_VA_W-1:0]    req_addr,
    input  logic [1:0]           req_kind,
    input  logic                 map_on,
    output logic                 out_valid,
    output logic [P_RA_W-1:0]    out_addr,
    output logic                 out_regref,
    output logic                 out_fault
);
    localparam int L_OFF_W = P_VA_W - P_PAGE_W;

    logic [P_PAGE_W-1:0]  vpn;
    logic [L_OFF_W-1:0]   voff;
    logic [P_FRAME_W-1:0] frame;
    logic [PERM_W-1:0]    perm_raw;
    logic                 is_reg;
    logic                 deny;
    xlat_s                nxt;
    xlat_s                cur;

    assign vpn    = req_addr[P_VA_W-1 -: P_PAGE_W];
    assign voff   = req_addr[L_OFF_W-1:0];
    assign is_reg = (req_addr < P_VA_W'(REG_SPAN));

    vat_page_table #(.IDX_W(P_PAGE_W), .DATA_W(P_FRAME_W)) u_frames (
        .clk(clk), .rst(rst),
        .we(wr_en && !wr_sel), .widx(wr_page), .wdata(wr_data),
        .ridx(vpn), .rdata(frame)
    );

    vat_page_table #(.IDX_W(P_PAGE_W), .DATA_W(PERM_W)) u_perms (
        .clk(clk), .rst(rst),
        .we(wr_en && wr_sel), .widx(wr_page), .wdata(wr_data[PERM_W-1:0]),
        .ridx(vpn), .rdata(perm_raw)
    );

    vat_perm_check u_check (
        .code(perm_e'(perm_raw)),
        .kind(kind_e'(req_kind)),
        .checked(req_valid && map_on && !is_reg),
        .deny(deny)
    );

    always_comb begin
        nxt = '0;
        if (req_valid) begin
            if (is_reg) begin
                nxt.valid  = 1'b1;
                nxt.regref = 1'b1;
                nxt.addr   = P_RA_W'(req_addr);
            end else if (!map_on) begin
                nxt.valid = 1'b1;
                nxt.addr  = P_RA_W'(req_addr);
            end else if (deny) begin
                nxt.fault = 1'b1;
            end else begin
                nxt.valid = 1'b1;
                nxt.addr  = {frame, voff};
            end
        end
    end

    vat_out_stage u_stage (.clk(clk), .rst(rst), .nxt(nxt), .cur(cur));

    assign out_valid  = cur.valid;
    assign out_addr   = cur.addr;
    assign out_regref = cur.regref;
    assign out_fault  = cur.fault;

    // idle cycle yields quiet outputs one cycle later (R9)
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!out_valid && !out_fault && !out_regref));
    // any request yields exactly one of valid or fault (R9)
    p_one_result_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_valid != out_fault));
    // offset bits survive translation (R4)
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_valid |-> out_addr[L_OFF_W-1:0] == $past(req_addr[L_OFF_W-1:0])));
    // pass-through mode (R5)
    p_passthru_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !map_on) |=> (out_valid && out_addr == P_RA_W'($past(req_addr))));
endmodule

// File: tb/vat_translator_bench.sv
module vat_translator_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_sel, req_valid, map_on;
    logic [7:0]  wr_page;
    logic [12:0] wr_data;
    logic [16:0] req_addr;
    logic [1:0]  req_kind;
    logic        out_valid, out_regref, out_fault;
    logic [21:0] out_addr;

    int checks = 0;
    int errors = 0;

    int unsigned fmodel [256];
    int unsigned pmodel [256];

    bit          e_valid, e_reg, e_fault;
    int unsigned e_addr;
    string       e_tag;

    always #2 clk = ~clk;

    vat_translator u_vat_translator (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_page(wr_page), .wr_data(wr_data), .req_valid(req_valid),
        .req_addr(req_addr), .req_kind(req_kind), .map_on(map_on),
        .out_valid(out_valid), .out_addr(out_addr),
        .out_regref(out_regref), .out_fault(out_fault)
    );

    function automatic bit allowed(int unsigned code, int unsigned kind);
        if (code == 0) return 1;
        if (code == 1) return kind != 1;
        if (code == 2) return kind == 0 || kind == 3;
        return 0;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== e_valid || out_regref !== e_reg ||
            out_fault !== e_fault || out_addr !== 22'(e_addr)) begin
            errors++;
            $display("FAIL %s: got v=%0b r=%0b f=%0b a=%h expected v=%0b r=%0b f=%0b a=%h",
                     e_tag, out_valid, out_regref, out_fault, out_addr,
                     e_valid, e_reg, e_fault, e_addr);
        end
    endtask

    // one cycle: drive at negedge, model result, sample at next negedge
    task automatic cyc(bit we, bit sel, int unsigned pg, int unsigned dat,
                       bit rv, int unsigned va, int unsigned kd, bit mo, string note);
        int unsigned vpn;
        wr_en = we; wr_sel = sel; wr_page = 8'(pg); wr_data = 13'(dat);
        req_valid = rv; req_addr = 17'(va); req_kind = 2'(kd); map_on = mo;
        vpn = (va >> 9) & 255;
        e_valid = 0; e_reg = 0; e_fault = 0; e_addr = 0;
        if (!rv) e_tag = "R9 idle";
        else if (va < 16) begin
            e_valid = 1; e_reg = 1; e_addr = va; e_tag = "R2 register";
        end else if (!mo) begin
            e_valid = 1; e_addr = va; e_tag = "R5 unmapped";
        end else if (!allowed(pmodel[vpn], kd)) begin
            e_fault = 1; e_tag = "R6 R7 denied";
        end else begin
            e_valid = 1; e_addr = (fmodel[vpn] << 9) | (va & 511); e_tag = "R3 R4 mapped";
        end
        if (note != "") e_tag = note;
        if (we) begin
            if (sel) pmodel[pg] = dat & 3;
            else     fmodel[pg] = dat & 13'h1fff;
        end
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin fmodel[i] = 0; pmodel[i] = 0; end
        rst = 1; wr_en = 0; wr_sel = 0; wr_page = 0; wr_data = 0;
        req_valid = 1; req_addr = 17'h1_2345; req_kind = 1; map_on = 1;
        repeat (3) @(negedge clk);
        e_valid = 0; e_reg = 0; e_fault = 0; e_addr = 0; e_tag = "R1 reset outputs";
        compare();
        rst = 0;

        // R1: cleared tables translate to frame 0 with full permission
        cyc(0, 0, 0, 0, 1, 17'h1_2345, 1, 1, "R1 cleared table");
        cyc(0, 0, 0, 0, 1, 17'h0_7fff, 2, 1, "R1 cleared table");

        // R2: register window in every mode, even with a no-access code on page 0
        cyc(1, 1, 0, 3, 1, 5, 1, 1, "");
        for (int a = 0; a < 16; a++) cyc(0, 0, 0, 0, 1, a, a % 4, (a % 2) == 0, "");
        cyc(0, 0, 0, 0, 1, 16, 0, 1, "R6 page0 no access above window");

        // R8: load frames with varied data, pages 0..255
        for (int p = 0; p < 256; p++) cyc(1, 0, p, (p * 37 + 11) & 13'h1fff, 0, 0, 0, 1, "");
        // R8: permission codes cycle through all four values
        for (int p = 0; p < 256; p++) cyc(1, 1, p, (p * 5) & 3, 0, 0, 0, 1, "");

        // R3 R4 R6 R7: sweep pages and kinds
        for (int p = 0; p < 256; p++)
            for (int k = 0; k < 4; k++)
                cyc(0, 0, 0, 0, 1, (p << 9) | ((p * 91 + k * 7 + 16) & 511), k, 1, "");

        // R5: mapping off ignores frames and no-access pages
        for (int p = 0; p < 256; p += 17) cyc(0, 0, 0, 0, 1, (p << 9) | 300, 1, 0, "");

        // R8: same-cycle write sees old value, next cycle sees new
        cyc(1, 1, 40, 0, 0, 0, 0, 1, "");
        cyc(1, 0, 40, 13'h1abc, 1, (40 << 9) | 9, 1, 1, "R8 old frame same cycle");
        cyc(0, 0, 0, 0, 1, (40 << 9) | 9, 1, 1, "R8 new frame next cycle");
        cyc(1, 1, 40, 3, 1, (40 << 9) | 9, 0, 1, "R8 old code same cycle");
        cyc(0, 0, 0, 0, 1, (40 << 9) | 9, 0, 1, "R8 new code next cycle");
        // R8: code write ignores upper data bits
        cyc(1, 1, 41, 13'h1ff2, 0, 0, 0, 1, "");
        cyc(0, 0, 0, 0, 1, (41 << 9) | 1, 1, 1, "R8 code low bits only");
        cyc(0, 0, 0, 0, 1, (41 << 9) | 1, 3, 1, "R7 spare kind as read");

        // mixed traffic
        for (int i = 0; i < 400; i++)
            cyc($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 255),
                $urandom_range(0, 8191), $urandom_range(0, 3) != 0,
                ($urandom_range(0, 7) == 0) ? $urandom_range(0, 20) : $urandom_range(0, 131071),
                $urandom_range(0, 3), $urandom_range(0, 4) != 0, "");

        // R9: idle after traffic
        cyc(0, 0, 0, 0, 0, 17'h1_ffff, 2, 1, "");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule